// File: doc/BRIEF.md
# Quadrature Clock and Reset Generator

This block takes a fast oscillator and produces two clock phases at half its rate. The second phase trails the first by a quarter of the phase period. The first phase is the primary system clock. The block also produces one active-low system reset, which it builds from three sources: a power-fail indicator, a reset pushbutton, and a liveness strobe from the processor.

A reset request from any source restarts a hold counter. The reset output stays asserted until that counter runs out. It changes only at an oscillator edge on which the primary phase rises, so downstream logic sees it move in step with its own clock. The pushbutton passes through a synchronizer and a debounce filter before it can request a reset. The strobe watchdog forces a reset when the strobe has shown no edge for a set number of cycles. It can be left out at build time, which behaves as if the strobe were tied to a free-running clock. The hold, debounce and timeout intervals are parameters counted in oscillator cycles.

Top module: `quad_clk_rst_gen`

## Requirements
- R1: Once power-fail is released, `q0_o` inverts on every rising oscillator edge, so it runs at half the oscillator rate.
- R2: `q1_o` takes the value of `q0_o` on each falling oscillator edge. It therefore differs from `q0_o` between a rising edge and the next falling edge, and equals it between a falling edge and the next rising edge.
- R3: While `pwr_fail` is 1, `q0_o`, `q1_o` and `rst_n_o` are all 0.
- R4: After `pwr_fail` returns to 0, `rst_n_o` stays 0 for at least HOLD_CYC rising oscillator edges, and it is 1 no later than HOLD_CYC+4 edges.
- R5: Apart from entry into power-fail, `rst_n_o` changes only on a rising oscillator edge that drives `q0_o` from 0 to 1.
- R6: A pushbutton press (`btn_n` = 0) that lasts fewer than DEB_CYC cycles does not assert the reset, and neither does a train of such presses.
- R7: A press held for DEB_CYC+8 cycles drives `rst_n_o` to 0. The reset stays 0 while the button is held. It is 0 for HOLD_CYC+DEB_CYC cycles after release and 1 eight cycles after that.
- R8: While `wdt_strobe` toggles at intervals shorter than WDT_CYC cycles, the watchdog never asserts the reset.
- R9: With the watchdog enabled, if `wdt_strobe` stops toggling, `rst_n_o` is still 1 at WDT_CYC-15 cycles after its last edge and is 0 at WDT_CYC+8 cycles. The reset is then held for HOLD_CYC cycles and released within 16 more cycles once the strobe resumes.
- R10: With WDT_EN = 0, a stopped strobe never asserts the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Fast oscillator clock |
| pwr_fail | input | 1 | Power-fail indicator, 1 = supply not good; also the block's synchronous reset |
| btn_n | input | 1 | Raw reset pushbutton, 0 = pressed |
| wdt_strobe | input | 1 | Liveness strobe; any edge counts as a sign of life |
| q0_o | output | 1 | Primary clock phase, half oscillator rate |
| q1_o | output | 1 | Secondary phase, a quarter period behind q0_o |
| rst_n_o | output | 1 | System reset, 0 = asserted |

## Verification
The assertions assume that `pwr_fail` is sampled cleanly at the oscillator edge. They also assume that each power-fail interval lasts for at least two rising edges, so the cycle after release can be told apart from the reset itself. The bench respects both: it changes `pwr_fail`, `btn_n` and `wdt_strobe` one nanosecond after a rising edge, far from either oscillator edge, and it holds power-fail for several cycles. The button and strobe inputs are asynchronous in principle, and the bench times its windows with margins that cover the synchronizer stages and the wait for phase alignment.

// File: rtl/qcr_pkg.sv
package qcr_pkg;
  localparam int unsigned DEFAULT_SYNC = 2;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/qcr_phase_gen.sv
module qcr_phase_gen (
  input  logic osc_clk,
  input  logic rst,
  output logic q0,
  output logic q1
);
  always_ff @(posedge osc_clk) begin
    if (rst) q0 <= 1'b0;
    else     q0 <= ~q0;
  end

  always_ff @(negedge osc_clk) begin
    if (rst) q1 <= 1'b0;
    else     q1 <= q0;
  end
endmodule

// File: rtl/qcr_debounce.sv
module qcr_debounce #(
  parameter int unsigned DEB_CYC = 16,
  parameter int unsigned SYNC    = qcr_pkg::DEFAULT_SYNC
) (
  input  logic osc_clk,
  input  logic rst,
  input  logic raw_n,
  output logic pressed
);
  localparam int unsigned CW = qcr_pkg::cnt_width(DEB_CYC);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic [SYNC-1:0] sync_sh;
  logic            level;
  logic [CW-1:0]   cnt;

  always_ff @(posedge osc_clk) begin
    if (rst) sync_sh <= '1;
    else     sync_sh <= {sync_sh[SYNC-2:0], raw_n};
  end

  always_ff @(posedge osc_clk) begin
    if (rst) begin
      level <= 1'b1;
      cnt   <= '0;
    end else if (sync_sh[SYNC-1] == level) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      level <= sync_sh[SYNC-1];
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign pressed = ~level;
endmodule

// File: rtl/qcr_watchdog.sv
module qcr_watchdog #(
  parameter int unsigned WDT_CYC = 1024,
  parameter bit          WDT_EN  = 1'b1,
  parameter int unsigned SYNC    = qcr_pkg::DEFAULT_SYNC
) (
  input  logic osc_clk,
  input  logic rst,
  input  logic strobe,
  input  logic sys_in_reset,
  output logic trip
);
  generate
    if (WDT_EN) begin : g_on
      localparam int unsigned CW = qcr_pkg::cnt_width(WDT_CYC);
      localparam logic [CW-1:0] LAST = CW'(WDT_CYC - 1);
      logic [SYNC:0] sync_sh;
      logic [CW-1:0] cnt;
      logic          seen_edge;

      always_ff @(posedge osc_clk) begin
        if (rst) sync_sh <= '0;
        else     sync_sh <= {sync_sh[SYNC-1:0], strobe};
      end

      assign seen_edge = sync_sh[SYNC] ^ sync_sh[SYNC-1];
      assign trip      = (cnt == LAST);

      always_ff @(posedge osc_clk) begin
        if (rst || sys_in_reset || seen_edge || trip) cnt <= '0;
        else                                          cnt <= cnt + 1'b1;
      end
    end else begin : g_off
      logic unused_inputs;
      assign unused_inputs = ^{strobe, sys_in_reset, rst, osc_clk};
      assign trip = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/qcr_hold.sv
module qcr_hold #(
  parameter int unsigned HOLD_CYC = 4096
) (
  input  logic osc_clk,
  input  logic rst,
  input  logic req,
  input  logic q0,
  output logic rst_n
);
  localparam int unsigned CW = qcr_pkg::cnt_width(HOLD_CYC);
  localparam logic [CW-1:0] FULL = CW'(HOLD_CYC);

  logic [CW-1:0] cnt;
  logic          busy;

  always_ff @(posedge osc_clk) begin
    if (rst || req)    cnt <= FULL;
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign busy = req | (cnt != 0);

  // q0 low now means this edge raises it: the only edge allowed to move rst_n
  always_ff @(posedge osc_clk) begin
    if (rst)      rst_n <= 1'b0;
    else if (!q0) rst_n <= ~busy;
  end
endmodule

// File: rtl/quad_clk_rst_gen.sv
module quad_clk_rst_gen #(
  parameter int unsigned HOLD_CYC    = 200000,
  parameter int unsigned DEB_CYC     = 20000,
  parameter int unsigned WDT_CYC     = 400000,
  parameter bit          WDT_EN      = 1'b1,
  parameter int unsigned SYNC_STAGES = qcr_pkg::DEFAULT_SYNC
) (
  input  logic osc_clk,
  input  logic pwr_fail,
  input  logic btn_n,
  input  logic wdt_strobe,
  output logic q0_o,
  output logic q1_o,
  output logic rst_n_o
);
  logic btn_pressed;
  logic wdt_trip;

  qcr_phase_gen u_phase (
    .osc_clk (osc_clk),
    .rst     (pwr_fail),
    .q0      (q0_o),
    .q1      (q1_o)
  );

  qcr_debounce #(.DEB_CYC(DEB_CYC), .SYNC(SYNC_STAGES)) u_btn (
    .osc_clk (osc_clk),
    .rst     (pwr_fail),
    .raw_n   (btn_n),
    .pressed (btn_pressed)
  );

  qcr_watchdog #(.WDT_CYC(WDT_CYC), .WDT_EN(WDT_EN), .SYNC(SYNC_STAGES)) u_wdt (
    .osc_clk      (osc_clk),
    .rst          (pwr_fail),
    .strobe       (wdt_strobe),
    .sys_in_reset (~rst_n_o),
    .trip         (wdt_trip)
  );

  qcr_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .osc_clk (osc_clk),
    .rst     (pwr_fail),
    .req     (btn_pressed | wdt_trip),
    .q0      (q0_o),
    .rst_n   (rst_n_o)
  );
endmodule

// File: rtl/qcr_checker.sv
module qcr_checker #(
  parameter int unsigned HOLD_CYC = 16
) (
  input logic osc_clk,
  input logic pwr_fail,
  input logic q0_o,
  input logic q1_o,
  input logic rst_n_o
);
  localparam int unsigned CW = qcr_pkg::cnt_width(HOLD_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(HOLD_CYC + 1);

  logic [CW-1:0] since_fail;

  always_ff @(posedge osc_clk) begin
    if (pwr_fail)              since_fail <= '0;
    else if (since_fail != SAT) since_fail <= since_fail + 1'b1;
  end

  AST_Q0_TOGGLES: assert property (@(posedge osc_clk) disable iff (pwr_fail)
    !$past(pwr_fail) |-> (q0_o != $past(q0_o))); // R1

  AST_Q1_FOLLOWS: assert property (@(posedge osc_clk) disable iff (pwr_fail)
    !$past(pwr_fail) |-> (q1_o == q0_o)); // R2

  AST_HOLD_MIN: assert property (@(posedge osc_clk) disable iff (pwr_fail)
    (since_fail < CW'(HOLD_CYC)) |-> !rst_n_o); // R4

  AST_RST_ON_RISE: assert property (@(posedge osc_clk) disable iff (pwr_fail)
    (!$past(pwr_fail) && !$stable(rst_n_o)) |-> q0_o); // R5
endmodule

bind quad_clk_rst_gen qcr_checker #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .osc_clk (osc_clk),
  .pwr_fail(pwr_fail),
  .q0_o    (q0_o),
  .q1_o    (q1_o),
  .rst_n_o (rst_n_o)
);

// File: tb/tb_quad_clk_rst_gen.sv
`timescale 1ns/100ps
module tb_quad_clk_rst_gen;
  localparam int HOLD = 24;
  localparam int DEB  = 8;
  localparam int WDT  = 64;

  logic osc_clk = 1'b0;
  always #2 osc_clk = ~osc_clk;

  logic pwr_fail = 1'b1;
  logic btn_n = 1'b1;
  logic strobe = 1'b0;
  logic strobe_run = 1'b1;
  logic q0, q1, rst_n, q0b, q1b, rst_nb;

  int errors = 0;
  int checks = 0;
  int r5_viol = 0;
  bit done = 1'b0;

  quad_clk_rst_gen #(.HOLD_CYC(HOLD), .DEB_CYC(DEB), .WDT_CYC(WDT), .WDT_EN(1'b1)) dut (
    .osc_clk(osc_clk), .pwr_fail(pwr_fail), .btn_n(btn_n), .wdt_strobe(strobe),
    .q0_o(q0), .q1_o(q1), .rst_n_o(rst_n));

  quad_clk_rst_gen #(.HOLD_CYC(HOLD), .DEB_CYC(DEB), .WDT_CYC(WDT), .WDT_EN(1'b0)) dut_nowdt (
    .osc_clk(osc_clk), .pwr_fail(pwr_fail), .btn_n(btn_n), .wdt_strobe(strobe),
    .q0_o(q0b), .q1_o(q1b), .rst_n_o(rst_nb));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge osc_clk);
    #1;
  endtask

  task automatic count_lows(input int n, output int lows);
    lows = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1);
      if (!rst_n || !rst_nb) lows++;
    end
  endtask

  // background strobe generator
  initial forever begin
    repeat (10) @(posedge osc_clk);
    #1;
    if (strobe_run) strobe = ~strobe;
  end

  // R5 monitor: rst_n may only move on an edge that raises q0
  initial begin
    logic prev_pf, prev_rn;
    prev_pf = 1'b1;
    prev_rn = 1'b0;
    forever begin
      @(posedge osc_clk);
      #0.5;
      if (!prev_pf && (rst_n != prev_rn) && !q0) r5_viol++;
      prev_pf = pwr_fail;
      prev_rn = rst_n;
    end
  end

  task automatic t_power;
    cyc(6);
    chk(q0 == 1'b0, "R3 q0 during power-fail", q0, 0);
    chk(q1 == 1'b0, "R3 q1 during power-fail", q1, 0);
    chk(rst_n == 1'b0, "R3 rst_n during power-fail", rst_n, 0);
    pwr_fail = 1'b0;
    cyc(HOLD);
    chk(rst_n == 1'b0, "R4 reset still held", rst_n, 0);
    cyc(4);
    chk(rst_n == 1'b1, "R4 reset released", rst_n, 1);
  endtask

  task automatic t_phase;
    logic prev;
    int bad_tog, bad_lead, bad_lag;
    bad_tog = 0; bad_lead = 0; bad_lag = 0;
    prev = q0;
    for (int i = 0; i < 10; i++) begin
      cyc(1);
      if (q0 == prev) bad_tog++;
      if (q1 == q0) bad_lead++;
      prev = q0;
      @(negedge osc_clk);
      #1;
      if (q1 != q0) bad_lag++;
    end
    chk(bad_tog == 0, "R1 q0 toggles each edge", bad_tog, 0);
    chk(bad_lead == 0, "R2 q1 differs before falling edge", bad_lead, 0);
    chk(bad_lag == 0, "R2 q1 matches after falling edge", bad_lag, 0);
  endtask

  task automatic t_alive;
    int lows;
    count_lows(300, lows);
    chk(lows == 0, "R8 live strobe keeps reset off", lows, 0);
  endtask

  task automatic t_btn_short;
    int lows;
    btn_n = 1'b0;
    cyc(DEB - 3);
    btn_n = 1'b1;
    count_lows(DEB + 12, lows);
    chk(lows == 0, "R6 short press ignored", lows, 0);
  endtask

  task automatic t_btn_bounce;
    int lows;
    for (int i = 0; i < 6; i++) begin
      btn_n = 1'b0;
      cyc(3);
      btn_n = 1'b1;
      cyc(3);
    end
    count_lows(20, lows);
    chk(lows == 0, "R6 bouncing press ignored", lows, 0);
  endtask

  task automatic t_btn_long;
    btn_n = 1'b0;
    cyc(DEB + 8);
    chk(rst_n == 1'b0, "R7 long press asserts reset", rst_n, 0);
    cyc(40);
    chk(rst_n == 1'b0, "R7 reset held while pressed", rst_n, 0);
    btn_n = 1'b1;
    cyc(HOLD + DEB);
    chk(rst_n == 1'b0, "R7 reset held after release", rst_n, 0);
    cyc(8);
    chk(rst_n == 1'b1, "R7 reset released", rst_n, 1);
  endtask

  task automatic t_wdt;
    strobe_run = 1'b0;
    cyc(12);
    strobe = ~strobe;
    cyc(WDT - 15);
    chk(rst_n == 1'b1, "R9 no early timeout", rst_n, 1);
    cyc(23);
    chk(rst_n == 1'b0, "R9 timeout asserts reset", rst_n, 0);
    chk(rst_nb == 1'b1, "R10 disabled watchdog ignores stopped strobe", rst_nb, 1);
    cyc(HOLD - 8);
    chk(rst_n == 1'b0, "R9 timeout reset held", rst_n, 0);
    strobe_run = 1'b1;
    cyc(16);
    chk(rst_n == 1'b1, "R9 reset released after hold", rst_n, 1);
    chk(rst_nb == 1'b1, "R10 disabled watchdog still released", rst_nb, 1);
  endtask

  initial begin
    t_power();
    t_phase();
    t_alive();
    t_btn_short();
    t_btn_bounce();
    t_btn_long();
    t_wdt();
    t_alive();
    chk(r5_viol == 0, "R5 reset moves only on q0 rise", r5_viol, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge osc_clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule